// File: doc/BRIEF.md
# Fractional Rate Strobe Generator

This block emits a single-cycle strobe whose long-run rate is a rational fraction of its own clock. A phase accumulator of parameterised width adds one of two software-supplied increments on every cycle. The carry out of that addition is captured in a flag register. The flag is the strobe, and it also selects which increment is added on the following cycle. With a "normal" increment `ftr` and a "carry" increment `delta = 2^ACC_W - fdr + ftr`, the accumulator settles into a pattern of exactly `ftr` strobes in every `fdr` cycles. This holds for ratios that are not integer divisions, for example 2/5 or 7/16.

Software programs both increments through a small single-beat register port in the style of Wishbone. Software computes `delta` itself, including any reduction of the ratio, so the block contains no subtractor. Writing the carry increment restarts the accumulator from zero. Setting both increments to zero halts the strobe.

A compile-time variant with `PROGRAMMABLE = 0` holds the two increments at parameter values. In that variant, bus writes are acknowledged but have no effect.

Top module: `frac_strobe_gen`

## Requirements
- R1: After synchronous reset, `strobe` and `wb_ack` are 0, the accumulator is zero, and (in the programmable variant) both increment registers read back as 0.
- R2: A bus request (`wb_cyc` and `wb_stb` high while `wb_ack` is low) is acknowledged with `wb_ack` high for exactly one cycle, on the cycle after the request.
- R3: Address `wb_adr = 0` selects the normal increment `ftr`, and `wb_adr = 1` selects the carry increment `delta`. Both are ACC_W bits wide, are written when `wb_we` is high, and read back on `wb_dat_r` during the ack cycle.
- R4: The strobe is high for one cycle per carry. When `2*ftr <= fdr`, it is never high on two consecutive cycles.
- R5: With `delta = 2^ACC_W - fdr + ftr` and `ftr < fdr`, from the first strobe onward every run of `fdr` consecutive cycles holds exactly `ftr` strobes (checked for 1/3, 2/5 and 7/16).
- R6: A write to `delta` clears the accumulator and the carry flag. The strobe is low on the next cycle, and it first rises `ceil(2^ACC_W / ftr)` cycles after the write edge.
- R7: When `ftr` and `delta` are both zero and no strobe is active, the strobe stays low.
- R8: With `PROGRAMMABLE = 0`, the increments are fixed at `FIXED_FTR` and `FIXED_DELTA`. Writes are acknowledged but leave the read-back values and the strobe pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | 1 | Register select: 0 = ftr, 1 = delta |
| wb_dat_w | input | ACC_W | Write data |
| wb_dat_r | output | ACC_W | Read data, valid with ack |
| wb_ack | output | 1 | One-cycle acknowledge |
| strobe | output | 1 | Fractional-rate enable pulse |

## Verification
The bound checker checks on every cycle the handshake rules: ack only follows a request, it lasts one cycle, and it always answers a request. It also checks that the strobe is quiet after reset, that it drops right after a carry-increment write, and that it stays quiet while both increments are zero. Three properties need the directed scenarios instead: the exact count of strobes in each `fdr`-cycle window, the exact latency to the first strobe after a restart, and register read-back. Only the scenarios can show that the fixed variant ignores writes, as seen both in its read-back and in its unchanged strobe rate.

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
  parameter int ACC_W = 16,
  parameter bit PROGRAMMABLE = 1'b1,
  parameter logic [ACC_W-1:0] FIXED_FTR = '0,
  parameter logic [ACC_W-1:0] FIXED_DELTA = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic             wb_adr,
  input  logic [ACC_W-1:0] wb_dat_w,
  output logic [ACC_W-1:0] wb_dat_r,
  output logic             wb_ack,
  output logic             strobe
);

  localparam logic [ACC_W-1:0] FTR_INIT   = PROGRAMMABLE ? '0 : FIXED_FTR;
  localparam logic [ACC_W-1:0] DELTA_INIT = PROGRAMMABLE ? '0 : FIXED_DELTA;

  logic [ACC_W-1:0] acc_q, ftr_q, delta_q, rd_q;
  logic             carry_q, ack_q;
  logic [ACC_W:0]   sum;

  wire req      = wb_cyc & wb_stb & ~ack_q;
  wire wr_ftr   = PROGRAMMABLE & req & wb_we & ~wb_adr;
  wire wr_delta = PROGRAMMABLE & req & wb_we & wb_adr;

  assign sum      = {1'b0, acc_q} + {1'b0, carry_q ? delta_q : ftr_q};
  assign strobe   = carry_q;
  assign wb_ack   = ack_q;
  assign wb_dat_r = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ftr_q   <= FTR_INIT;
      delta_q <= DELTA_INIT;
    end else begin
      if (wr_ftr)   ftr_q   <= wb_dat_w;
      if (wr_delta) delta_q <= wb_dat_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wr_delta) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= sum[ACC_W-1:0];
      carry_q <= sum[ACC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      ack_q <= req;
      if (req && !wb_we) rd_q <= wb_adr ? delta_q : ftr_q;
    end
  end

endmodule

// File: rtl/frac_strobe_gen_chk.sv
module frac_strobe_gen_chk #(
  parameter int ACC_W = 16,
  parameter bit PROG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_cyc,
  input logic             wb_stb,
  input logic             wb_we,
  input logic             wb_adr,
  input logic             wb_ack,
  input logic             strobe,
  input logic [ACC_W-1:0] ftr_q,
  input logic [ACC_W-1:0] delta_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!strobe && !wb_ack));

  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);

  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_cyc && wb_stb));

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  // R6
  delta_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (PROG && wb_cyc && wb_stb && wb_we && wb_adr && !wb_ack) |=> !strobe);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ftr_q == '0 && delta_q == '0 && !strobe) |=> !strobe);

endmodule

bind frac_strobe_gen frac_strobe_gen_chk #(.ACC_W(ACC_W), .PROG(PROGRAMMABLE)) u_chk (
  .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
  .wb_adr(wb_adr), .wb_ack(wb_ack), .strobe(strobe),
  .ftr_q(ftr_q), .delta_q(delta_q)
);

// File: tb/test_frac_strobe_gen.sv
module test_frac_strobe_gen;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_p = 1'b0, cyc_f = 1'b0, stb = 1'b0, we = 1'b0, adr = 1'b0;
  logic [W-1:0] dw = '0;
  logic [W-1:0] dr_p, dr_f;
  logic ack_p, ack_f, str_p, str_f;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  frac_strobe_gen #(.ACC_W(W)) i_frac_strobe_gen (
    .clk(clk), .rst(rst), .wb_cyc(cyc_p), .wb_stb(stb), .wb_we(we), .wb_adr(adr),
    .wb_dat_w(dw), .wb_dat_r(dr_p), .wb_ack(ack_p), .strobe(str_p));

  frac_strobe_gen #(.ACC_W(W), .PROGRAMMABLE(1'b0), .FIXED_FTR(8'd1), .FIXED_DELTA(8'd253))
  i_frac_strobe_gen_fixed (
    .clk(clk), .rst(rst), .wb_cyc(cyc_f), .wb_stb(stb), .wb_we(we), .wb_adr(adr),
    .wb_dat_w(dw), .wb_dat_r(dr_f), .wb_ack(ack_f), .strobe(str_f));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sel_str(input bit fx);
    return fx ? str_f : str_p;
  endfunction

  task automatic bus_write(input bit fx, input bit a, input int d);
    @(negedge clk);
    if (fx) cyc_f = 1'b1; else cyc_p = 1'b1;
    stb = 1'b1; we = 1'b1; adr = a; dw = W'(d);
    @(negedge clk);
    check("R2 write ack", int'(fx ? ack_f : ack_p), 1);
    cyc_p = 1'b0; cyc_f = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input bit fx, input bit a, input int exp, input string tag);
    @(negedge clk);
    if (fx) cyc_f = 1'b1; else cyc_p = 1'b1;
    stb = 1'b1; we = 1'b0; adr = a;
    @(negedge clk);
    check("R2 read ack", int'(fx ? ack_f : ack_p), 1);
    check(tag, int'(fx ? dr_f : dr_p), exp);
    cyc_p = 1'b0; cyc_f = 1'b0; stb = 1'b0;
    @(negedge clk);
    check("R2 ack drops", int'(fx ? ack_f : ack_p), 0);
  endtask

  task automatic count_windows(input bit fx, input int ftr, input int fdr, input int nwin,
                               input string tag);
    int n = 0;
    while (!sel_str(fx) && n < 600) begin @(negedge clk); n++; end
    check({tag, " first strobe seen"}, int'(sel_str(fx)), 1);
    for (int w = 0; w < nwin; w++) begin
      int cnt = 0;
      int run = 0;
      for (int i = 0; i < fdr; i++) begin
        if (i > 0 || w > 0) @(negedge clk);
        if (sel_str(fx)) begin cnt++; run++; end else run = 0;
        if (run > 1) check("R4 no back-to-back strobe", run, 1);
      end
      check(tag, cnt, ftr);
    end
  endtask

  task automatic t_reset;
    check("R1 strobe after reset", int'(str_p), 0);
    check("R1 ack after reset", int'(ack_p), 0);
    bus_read(1'b0, 1'b0, 0, "R1 ftr reset value");
    bus_read(1'b0, 1'b1, 0, "R1 delta reset value");
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); seen += int'(str_p); end
      check("R7 no strobe with zero increments", seen, 0);
    end
  endtask

  task automatic t_ratio(input int ftr, input int fdr);
    int delta = (1 << W) - fdr + ftr;
    int exp_m = ((1 << W) + ftr - 1) / ftr;
    int n = 0;
    bus_write(1'b0, 1'b0, ftr);
    bus_read(1'b0, 1'b0, ftr, "R3 ftr readback");
    bus_write(1'b0, 1'b1, delta);
    do begin @(negedge clk); n++; end while (!str_p && n < 600);
    check("R6 first strobe latency after delta write", n, exp_m);
    count_windows(1'b0, ftr, fdr, 4, "R5 strobes per window");
    bus_read(1'b0, 1'b1, delta, "R3 delta readback");
  endtask

  task automatic t_stop;
    int seen = 0;
    bus_write(1'b0, 1'b0, 0);
    bus_write(1'b0, 1'b1, 0);
    @(negedge clk);
    check("R6 strobe low after delta write", int'(str_p), 0);
    for (int i = 0; i < 600; i++) begin @(negedge clk); seen += int'(str_p); end
    check("R7 strobe stopped", seen, 0);
  endtask

  task automatic t_fixed;
    bus_read(1'b1, 1'b0, 1, "R8 fixed ftr value");
    bus_read(1'b1, 1'b1, 253, "R8 fixed delta value");
    bus_write(1'b1, 1'b0, 55);
    bus_write(1'b1, 1'b1, 9);
    bus_read(1'b1, 1'b0, 1, "R8 fixed ftr ignores write");
    bus_read(1'b1, 1'b1, 253, "R8 fixed delta ignores write");
    count_windows(1'b1, 1, 4, 5, "R8 fixed rate");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ratio(1, 3);
    t_ratio(2, 5);
    t_ratio(7, 16);
    t_stop();
    t_fixed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule